// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a host I/O port and a PCI cycle generator. It holds the configuration address register behind a pair of fixed I/O ports. For each host I/O access it picks one of three outcomes: run a configuration cycle on the bus, pass the access on as an ordinary I/O cycle, or answer the access itself. It answers on its own for the address register, for the host bridge's own configuration space, and for configuration accesses to device numbers that have no select line.

For configuration cycles the block builds the address-phase AD word. When the target bus is 0 it builds a Type 0 word, with a one-hot select line taken from the device number. For any other bus it builds a Type 1 word. Bus protocol timing and arbitration belong to the PCI side. This block only raises a request, holds it, and waits for a done pulse.

The host holds `host_req` until it sees `host_ack` and drops it in the same cycle. An access answered locally is acknowledged one cycle after it is accepted. An access that goes to the bus is acknowledged in the cycle in which `pci_done` is high.

Top module: `pci_cfg_xlat`

## Requirements
- R1: After reset the address register reads 00000000h, `pci_req` and `host_ack` are low, and accesses to the data port are passed on as I/O cycles.
- R2: A read or write to the address port (0CF8h) with all four byte enables set accesses the address register and starts no bus cycle. Bits 30:24 and 1:0 always read back as 0.
- R3: A byte or word access at the address port becomes an I/O cycle, and the address register keeps its value.
- R4: While the enable bit (bit 31) is 0, a data-port (0CFCh) access becomes an I/O cycle whose AD is the zero-extended host address.
- R5: With the enable bit set, bus 00h and a device number from 1 to 21, the cycle is Type 0. AD[1:0]=00, AD[10:2] are copied from the register, and exactly one line among AD[31:11] is set: AD[10+device]. Device 1 selects AD[11] and device 21 selects AD[31].
- R6: With the enable bit set and a non-zero bus number, the cycle is Type 1. AD = {8'h00, register bits 23:2, 2'b01}.
- R7: `pci_kind` is encoded as 00 I/O read, 01 I/O write, 10 configuration read, 11 configuration write. The host byte enables and write data pass through to the cycle unchanged.
- R8: A configuration access to bus 0, device 0 is answered internally with no bus cycle. A read of register 0, function 0 returns the BRIDGE_ID parameter. Other reads return 0, and writes have no effect.
- R9: A Type 0 access with device 22 to 31 starts no bus cycle. A read returns FFFFFFFFh and a write is dropped.
- R10: A bus cycle holds `pci_req`, `pci_kind`, `pci_ad` and `pci_be` stable until `pci_done`. `host_ack` stays low until then, then rises in the `pci_done` cycle with `host_rdata` equal to `pci_rdata`. Each ack lasts one cycle.
- R11: An access to any other I/O address becomes an I/O cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host I/O byte address |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_ack | output | 1 | Access complete, one cycle |
| pci_req | output | 1 | Bus cycle request, held until done |
| pci_kind | output | 2 | Cycle kind, encoded as in R7 |
| pci_ad | output | 32 | Address-phase AD word |
| pci_be | output | 4 | Byte enables for the cycle |
| pci_wdata | output | 32 | Write data for the cycle |
| pci_rdata | input | 32 | Read data from the bus side |
| pci_done | input | 1 | Bus cycle completion pulse |

## Verification
The bench targets the edges of the device window: devices 1 and 21 must land on AD[11] and AD[31], and devices 22 and 31 must not reach the bus at all. An off-by-one shift would put the select on the wrong line, or would leak a cycle with no select line set.

It writes ones into the reserved and type bits and checks that they read back as 0. It sends a byte write to the address port, which must be forwarded and must leave the register untouched. A design that decoded the port without checking the byte enables would corrupt the register instead.

It also checks that bus 0, device 0 is claimed internally and that writes there do not stick. Finally, it stalls `pci_done` for several cycles. A design that acknowledged early, or let the request fields drift, would return the wrong data.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int unsigned AD_W  = 32;
  localparam int unsigned FLD_W = 22;  // address register bits 23:2

  typedef enum logic [2:0] {
    OUT_IO,
    OUT_CFG,
    OUT_ADDR_RD,
    OUT_ADDR_WR,
    OUT_BRIDGE,
    OUT_ABORT
  } outcome_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_RESP
  } state_e;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import pci_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_enable_bit,
  input  logic [FLD_W-1:0] wr_fld,
  output logic             en_q,
  output logic [FLD_W-1:0] fld_q
);
  logic             en_d;
  logic [FLD_W-1:0] fld_d;

  always_comb begin
    en_d  = en_q;
    fld_d = fld_q;
    if (wr_en) begin
      en_d  = wr_enable_bit;
      fld_d = wr_fld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      fld_q <= '0;
    end else begin
      en_q  <= en_d;
      fld_q <= fld_d;
    end
  end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import pci_cfg_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]  ADDR_PORT   = 16'h0CF8,
  parameter logic [ADDR_W-1:0]  DATA_PORT   = 16'h0CFC,
  parameter int unsigned        IDSEL_BASE  = 11,
  parameter int unsigned        IDSEL_COUNT = 21
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [3:0]        host_be,
  input  logic              host_we,
  input  logic              cfg_en,
  input  logic [FLD_W-1:0]  cfg_fld,
  output outcome_e          outcome,
  output logic [AD_W-1:0]   ad
);
  localparam int unsigned PAD_W = AD_W - IDSEL_COUNT;

  logic                   hit_addr, hit_data, full_dw;
  logic [7:0]             bus;
  logic [4:0]             dev;
  logic                   dev_ok;
  logic [IDSEL_COUNT-1:0] idsel;
  logic [AD_W-1:0]        ad_t0, ad_t1, ad_io;

  assign hit_addr = host_addr[ADDR_W-1:2] == ADDR_PORT[ADDR_W-1:2];
  assign hit_data = host_addr[ADDR_W-1:2] == DATA_PORT[ADDR_W-1:2];
  assign full_dw  = host_be == 4'hF;
  assign bus      = cfg_fld[21:14];
  assign dev      = cfg_fld[13:9];
  assign dev_ok   = (dev != 5'd0) && (32'(dev) <= IDSEL_COUNT);

  for (genvar i = 0; i < IDSEL_COUNT; i++) begin : g_idsel
    assign idsel[i] = 32'(dev) == (i + 1);
  end

  assign ad_t0 = ({{PAD_W{1'b0}}, idsel} << IDSEL_BASE)
               | {{(AD_W-11){1'b0}}, cfg_fld[8:0], 2'b00};
  assign ad_t1 = {8'h00, cfg_fld, 2'b01};
  assign ad_io = {{(AD_W-ADDR_W){1'b0}}, host_addr};

  always_comb begin
    outcome = OUT_IO;
    ad      = ad_io;
    if (hit_addr && full_dw) begin
      outcome = host_we ? OUT_ADDR_WR : OUT_ADDR_RD;
    end else if (hit_data && cfg_en) begin
      if (bus != 8'h00) begin
        outcome = OUT_CFG;
        ad      = ad_t1;
      end else if (dev == 5'd0) begin
        outcome = OUT_BRIDGE;
      end else if (dev_ok) begin
        outcome = OUT_CFG;
        ad      = ad_t0;
      end else begin
        outcome = OUT_ABORT;
      end
    end
  end
endmodule

// File: rtl/pci_cfg_xlat.sv
module pci_cfg_xlat
  import pci_cfg_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]  ADDR_PORT   = 16'h0CF8,
  parameter logic [ADDR_W-1:0]  DATA_PORT   = 16'h0CFC,
  parameter int unsigned        IDSEL_BASE  = 11,
  parameter int unsigned        IDSEL_COUNT = 21,
  parameter logic [31:0]        BRIDGE_ID   = 32'h5A5A_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [3:0]        host_be,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_ack,
  output logic              pci_req,
  output logic [1:0]        pci_kind,
  output logic [31:0]       pci_ad,
  output logic [3:0]        pci_be,
  output logic [31:0]       pci_wdata,
  input  logic [31:0]       pci_rdata,
  input  logic              pci_done
);
  state_e           state_q, state_d;
  outcome_e         outcome;
  logic [AD_W-1:0]  dec_ad;
  logic             cfg_en;
  logic [FLD_W-1:0] cfg_fld;
  logic [31:0]      cfg_view;
  logic             accept, addr_wr, load_pci;
  logic [31:0]      resp_q, resp_d;
  logic [1:0]       kind_d;

  cfg_addr_reg u_areg (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (addr_wr),
    .wr_enable_bit (host_wdata[31]),
    .wr_fld        (host_wdata[23:2]),
    .en_q          (cfg_en),
    .fld_q         (cfg_fld)
  );

  cfg_decode #(
    .ADDR_W      (ADDR_W),
    .ADDR_PORT   (ADDR_PORT),
    .DATA_PORT   (DATA_PORT),
    .IDSEL_BASE  (IDSEL_BASE),
    .IDSEL_COUNT (IDSEL_COUNT)
  ) u_dec (
    .host_addr (host_addr),
    .host_be   (host_be),
    .host_we   (host_we),
    .cfg_en    (cfg_en),
    .cfg_fld   (cfg_fld),
    .outcome   (outcome),
    .ad        (dec_ad)
  );

  assign cfg_view = {cfg_en, 7'b0, cfg_fld, 2'b00};
  assign accept   = (state_q == ST_IDLE) && host_req;
  assign addr_wr  = accept && (outcome == OUT_ADDR_WR);
  assign load_pci = accept && ((outcome == OUT_IO) || (outcome == OUT_CFG));
  assign kind_d   = {outcome == OUT_CFG, host_we};

  // next state and local response
  always_comb begin
    state_d = state_q;
    resp_d  = resp_q;
    case (state_q)
      ST_IDLE: if (host_req) begin
        if (load_pci) begin
          state_d = ST_BUSY;
        end else begin
          state_d = ST_RESP;
          case (outcome)
            OUT_ADDR_RD: resp_d = cfg_view;
            OUT_BRIDGE:  resp_d = (!host_we && cfg_fld[8:0] == 9'd0) ? BRIDGE_ID : 32'h0;
            OUT_ABORT:   resp_d = 32'hFFFF_FFFF;
            default:     resp_d = 32'h0;
          endcase
        end
      end
      ST_BUSY: if (pci_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      resp_q  <= '0;
    end else begin
      state_q <= state_d;
      resp_q  <= resp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_kind  <= '0;
      pci_ad    <= '0;
      pci_be    <= '0;
      pci_wdata <= '0;
    end else if (load_pci) begin
      pci_kind  <= kind_d;
      pci_ad    <= dec_ad;
      pci_be    <= host_be;
      pci_wdata <= host_wdata;
    end
  end

  assign pci_req    = state_q == ST_BUSY;
  assign host_ack   = (state_q == ST_RESP) || (pci_req && pci_done);
  assign host_rdata = pci_req ? pci_rdata : resp_q;

  assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  assert_hold_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req && !pci_done) |=> (pci_req && $stable(pci_ad) && $stable(pci_be) && $stable(pci_kind)));

  assert_idsel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req && pci_kind[1] && pci_ad[1:0] == 2'b00) |-> ($countones(pci_ad[31:11]) == 1));

  assert_type1_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req && pci_kind[1] && pci_ad[1:0] == 2'b01) |-> (pci_ad[31:24] == 8'h00));

  assert_addr_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_view) |-> $past(host_req && host_we && host_be == 4'hF && state_q == ST_IDLE
                                 && host_addr[ADDR_W-1:2] == ADDR_PORT[ADDR_W-1:2]));
endmodule

// File: tb/pci_cfg_xlat_tb.sv
`timescale 1ns/1ps
module pci_cfg_xlat_tb;
  localparam logic [31:0] BRIDGE_ID = 32'h5A5A_0001;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [15:0] host_addr;
  logic [3:0]  host_be;
  logic [31:0] host_wdata, host_rdata;
  logic        host_ack;
  logic        pci_req;
  logic [1:0]  pci_kind;
  logic [31:0] pci_ad, pci_wdata, pci_rdata;
  logic [3:0]  pci_be;
  logic        pci_done;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pci_cfg_xlat #(.BRIDGE_ID(BRIDGE_ID)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .pci_req(pci_req), .pci_kind(pci_kind),
    .pci_ad(pci_ad), .pci_be(pci_be), .pci_wdata(pci_wdata),
    .pci_rdata(pci_rdata), .pci_done(pci_done)
  );

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        bus;
    logic [1:0]  kind;
    logic [31:0] ad;
    logic [31:0] prd;
    logic [31:0] exp_rd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0CF8, 4'hF, 32'hFF00_0A0F, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd2},          // R2 write, junk in reserved bits
    '{1'b0, 16'h0CF8, 4'hF, 32'h0,         1'b0, 2'b00, 32'h0, 32'h0, 32'h8000_0A0C, 8'd2},  // R2 readback
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,         1'b1, 2'b10, 32'h0000_0A0C, 32'h1234_5678, 32'h1234_5678, 8'd5}, // R5 dev1 -> AD11
    '{1'b1, 16'h0CF8, 4'hF, 32'h8000_A800, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd2},
    '{1'b1, 16'h0CFC, 4'h3, 32'hDEAD_BEEF, 1'b1, 2'b11, 32'h8000_0000, 32'h0, 32'h0, 8'd7},  // R7 dev21 -> AD31, be pass
    '{1'b1, 16'h0CF8, 4'hF, 32'h8005_1234, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd2},
    '{1'b0, 16'h0CFC, 4'h4, 32'h0,         1'b1, 2'b10, 32'h0005_1235, 32'hA5A5_0000, 32'hA5A5_0000, 8'd6}, // R6 type 1
    '{1'b1, 16'h0CF8, 4'h1, 32'h0000_0011, 1'b1, 2'b01, 32'h0000_0CF8, 32'h0, 32'h0, 8'd3},  // R3 byte write forwarded
    '{1'b0, 16'h0CF8, 4'hF, 32'h0,         1'b0, 2'b00, 32'h0, 32'h0, 32'h8005_1234, 8'd3},  // R3 register unchanged
    '{1'b1, 16'h0CF8, 4'hF, 32'h0000_0000, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd2},
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,         1'b1, 2'b00, 32'h0000_0CFC, 32'h0BAD_F00D, 32'h0BAD_F00D, 8'd4}, // R4
    '{1'b0, 16'h0080, 4'hF, 32'h0,         1'b1, 2'b00, 32'h0000_0080, 32'h55AA_55AA, 32'h55AA_55AA, 8'd11}, // R11
    '{1'b1, 16'h0CF8, 4'hF, 32'h8000_0004, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd2},
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,         1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd8},          // R8 bridge reg1 -> 0
    '{1'b1, 16'h0CF8, 4'hF, 32'h8000_0000, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd2},
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,         1'b0, 2'b00, 32'h0, 32'h0, BRIDGE_ID, 8'd8},      // R8 bridge id
    '{1'b1, 16'h0CFC, 4'hF, 32'h1111_2222, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd8},          // R8 write ignored
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,         1'b0, 2'b00, 32'h0, 32'h0, BRIDGE_ID, 8'd8},
    '{1'b1, 16'h0CF8, 4'hF, 32'h8000_B000, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd2},
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,         1'b0, 2'b00, 32'h0, 32'h0, 32'hFFFF_FFFF, 8'd9}, // R9 dev22
    '{1'b1, 16'h0CF8, 4'hF, 32'h8000_F800, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd2},
    '{1'b1, 16'h0CFC, 4'hF, 32'h7777_7777, 1'b0, 2'b00, 32'h0, 32'h0, 32'h0, 8'd9},          // R9 write dropped
    '{1'b0, 16'h0CFC, 4'hF, 32'h0,         1'b0, 2'b00, 32'h0, 32'h0, 32'hFFFF_FFFF, 8'd9}  // R9 dev31
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_io(input logic we, input logic [15:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input logic [31:0] prd, input int dly,
                       output logic seen, output logic [1:0] k, output logic [31:0] ad,
                       output logic [3:0] obe, output logic [31:0] owd,
                       output logic [31:0] rd, output logic bad);
    int  cnt;
    int  guard;
    logic fin;
    seen = 1'b0; bad = 1'b0; k = '0; ad = '0; obe = '0; owd = '0; rd = '0;
    cnt = 0; guard = 0; fin = 1'b0;
    @(negedge clk);
    pci_done = 1'b0;
    host_req = 1'b1; host_we = we; host_addr = a; host_be = be; host_wdata = wd;
    while (!fin) begin
      @(negedge clk);
      pci_done = 1'b0;
      guard++;
      if (guard > 200) begin
        failures++;
        $display("FAIL watchdog expired actual=no_ack expected=ack");
        host_req = 1'b0;
        fin = 1'b1;
      end else begin
        if (pci_req) begin
          if (!seen) begin
            seen = 1'b1; k = pci_kind; ad = pci_ad; obe = pci_be; owd = pci_wdata;
          end
          if ((pci_ad !== ad) || (pci_kind !== k) || (pci_be !== obe)) bad = 1'b1;
          cnt++;
          if (cnt >= dly) begin
            pci_done  = 1'b1;
            pci_rdata = prd;
          end
        end
        #1;
        if (host_ack) begin
          if (pci_req && !pci_done) bad = 1'b1;
          rd = host_rdata;
          host_req = 1'b0;
          fin = 1'b1;
        end else if (pci_req && pci_done) begin
          bad = 1'b1;
        end
      end
    end
    @(negedge clk);
    pci_done = 1'b0;
  endtask

  initial begin
    logic        seen, bad;
    logic [1:0]  k;
    logic [31:0] ad, owd, rd;
    logic [3:0]  obe;
    string       tag;

    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0;
    host_be = '0; host_wdata = '0; pci_rdata = '0; pci_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 ack idle", {31'b0, host_ack}, 32'h0);
    chk("R1 req idle", {31'b0, pci_req}, 32'h0);
    do_io(1'b0, 16'h0CF8, 4'hF, 32'h0, 32'h0, 1, seen, k, ad, obe, owd, rd, bad);
    chk("R1 addr reg reset", rd, 32'h0);
    chk("R1 addr read no cycle", {31'b0, seen}, 32'h0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      do_io(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wdata, VEC[i].prd, 2,
            seen, k, ad, obe, owd, rd, bad);
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      chk({tag, " bus"}, {31'b0, seen}, {31'b0, VEC[i].bus});
      if (VEC[i].bus) begin
        chk({tag, " kind"}, {30'b0, k}, {30'b0, VEC[i].kind});
        chk({tag, " ad"}, ad, VEC[i].ad);
        chk({tag, " be"}, {28'b0, obe}, {28'b0, VEC[i].be});
        if (VEC[i].we) chk({tag, " wdata"}, owd, VEC[i].wdata);
        chk({tag, " R10 protocol"}, {31'b0, bad}, 32'h0);
      end
      if (!VEC[i].we) chk({tag, " rdata"}, rd, VEC[i].exp_rd);
    end

    // R10: long stall on done, device 2 on AD12
    do_io(1'b1, 16'h0CF8, 4'hF, 32'h8000_1000, 32'h0, 1, seen, k, ad, obe, owd, rd, bad);
    do_io(1'b0, 16'h0CFC, 4'hF, 32'h0, 32'h1357_2468, 6, seen, k, ad, obe, owd, rd, bad);
    chk("R10 stalled bus", {31'b0, seen}, 32'h1);
    chk("R10 no early ack / stable fields", {31'b0, bad}, 32'h0);
    chk("R10 rdata with ack", rd, 32'h1357_2468);
    chk("R5 dev2 ad", ad, 32'h0000_1000);

    // R1: reset in mid-run clears enable
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_io(1'b0, 16'h0CF8, 4'hF, 32'h0, 32'h0, 1, seen, k, ad, obe, owd, rd, bad);
    chk("R1 addr reg after reset", rd, 32'h0);
    do_io(1'b0, 16'h0CFC, 4'hF, 32'h0, 32'hCAFE_0000, 1, seen, k, ad, obe, owd, rd, bad);
    chk("R1 data port is io after reset", {30'b0, k}, 32'h0);
    chk("R1 data port io ad", ad, 32'h0000_0CFC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule